// File: doc/BRIEF.md
# Interrupt Priority Resolver with Promotion

This block chooses which pending interrupt a small 8-bit CPU should take next. Its inputs are the reset-class events (a reset request, a clock-monitor failure and a watchdog failure), an illegal-opcode trap, a software-interrupt lock, one non-maskable external request that only the X bit can block, and sixteen maskable requests that are gated by their own enables and by the I bit. On every clock it registers the winning source, that source's vector address and a valid flag. When the CPU acknowledges, it produces a one-cycle grant and updates the X and I mask bits.

Software can promote any one maskable source to the head of the maskable group. The promotion register accepts a write only while the I bit is 1. A promoted source keeps its own enable, its masking and its vector. The block holds the X and I bits. They take the CPU's software writes to the condition-code byte and the return-from-interrupt restore. X can only be cleared by software and is set again only by entry through its own request or through the reset-class request.

A two-state controller covers the software interrupt. The states are ST_RUN and ST_SWI_LOCK. The transition T_SWI_ENTER moves from ST_RUN to ST_SWI_LOCK on `swi_fetch`. The transition T_VEC_DONE returns to ST_RUN on `vec_done`. In every other case the state holds.

Top module: `irq_prio_resolver`

## Requirements
- R1: Source codes are 0 reset request, 1 clock-monitor failure, 2 watchdog failure, 3 illegal opcode, 4 SWI, 5 X-masked request, and 6+k for maskable source k. Priority follows that order, with the lowest code winning, except that promotion can reorder the maskable group.
- R2: The vector for code n is 0xFFFE − 2·n. This holds whether or not the source is promoted.
- R3: `req_valid`, `req_id` and `req_vector` are registered and reflect the inputs sampled at the previous rising edge. When nothing is eligible, `req_valid` is 0 and `req_id` and `req_vector` keep their last values.
- R4: Maskable source k is eligible only when `mreq[k]`, `men[k]` and I=0 all hold. Among eligible sources the lowest k wins.
- R5: When the promoted source is eligible, it outranks every other maskable source. When it is not eligible, it does not win.
- R6: The promotion register resets to 0. `prom_we` loads `prom_wdata` only while I=1. A write made while I=0 has no effect.
- R7: The X-masked request is eligible only when X=0. X resets to 1. A write to the condition-code byte can clear X but cannot set it.
- R8: If `ack` is high at an edge while a source is eligible, `grant` is high for the following cycle and `grant_id` shows the winner. Every entry sets I. Entry through code 5 or code 0 also sets X. Maskable entry leaves X unchanged.
- R9: `rti` loads I from `rti_i` and loads X with X AND `rti_x`. `ack` takes precedence over `rti`, and `rti` takes precedence over `ccr_we`.
- R10: `swi_fetch` enters ST_SWI_LOCK. In that state code 4 is pending, and only codes 0 to 2 can outrank it. Codes 3, 5 and all maskable sources are blocked. `vec_done` returns the controller to ST_RUN.
- R11: After reset, `req_valid`=0, `req_id`=0, `req_vector`=0xFFFE, `grant`=0, X=1 and I=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rst_req | input | 1 | Reset-class request (code 0) |
| clkmon_fail | input | 1 | Clock-monitor failure (code 1) |
| cop_fail | input | 1 | Watchdog failure (code 2) |
| illop_req | input | 1 | Illegal-opcode trap (code 3) |
| swi_fetch | input | 1 | SWI opcode fetched; enters the lock |
| vec_done | input | 1 | SWI vector fetch completed; leaves the lock |
| xirq_req | input | 1 | Request masked only by X (code 5) |
| mreq | input | NUM_M | Maskable requests |
| men | input | NUM_M | Local enables of the maskable requests |
| ack | input | 1 | CPU acknowledge strobe |
| rti | input | 1 | Return-from-interrupt restore strobe |
| rti_x | input | 1 | X bit from the popped condition-code byte |
| rti_i | input | 1 | I bit from the popped condition-code byte |
| ccr_we | input | 1 | Software write of the condition-code byte |
| ccr_x | input | 1 | X value written (can only clear X) |
| ccr_i | input | 1 | I value written |
| prom_we | input | 1 | Promotion register write strobe |
| prom_wdata | input | SEL_W | Index of the maskable source to promote |
| req_valid | output | 1 | A source is eligible (registered) |
| req_id | output | ID_W | Code of the winning source |
| req_vector | output | VEC_W | Vector address of the winning source |
| grant | output | 1 | One-cycle grant after an accepted acknowledge |
| grant_id | output | ID_W | Code of the granted source |
| x_bit | output | 1 | Current X mask bit |
| i_bit | output | 1 | Current I mask bit |

## Verification
Each result appears one rising edge after its cause. A request pattern shows up on `req_*` after one edge. An acknowledge produces `grant` and the new X and I values after the same single edge, and `grant` falls after one more edge. A `swi_fetch` takes two edges to appear on `req_id`: one edge for the state register and one for the output register. After `vec_done`, the lock still shows for one edge before the trap behind it appears. The bench drives inputs just after a falling edge and samples at the next falling edge, so exactly one rising edge lies between stimulus and check. For the lock it waits the extra edge that the requirements account for.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_FIXED = 6;
    localparam int ID_RESET  = 0;
    localparam int ID_CLKMON = 1;
    localparam int ID_COP    = 2;
    localparam int ID_ILLOP  = 3;
    localparam int ID_SWI    = 4;
    localparam int ID_XIRQ   = 5;

    typedef enum logic [0:0] {
        ST_RUN      = 1'b0,
        ST_SWI_LOCK = 1'b1
    } lock_state_t;
endpackage

// File: rtl/irq_mask_pick.sv
module irq_mask_pick #(
    parameter int NUM_M = 16,
    parameter int SEL_W = $clog2(NUM_M)
) (
    input  logic [NUM_M-1:0] req,
    input  logic [NUM_M-1:0] en,
    input  logic             i_bit,
    input  logic [SEL_W-1:0] prom,
    output logic             any,
    output logic [SEL_W-1:0] idx
);
    logic [NUM_M-1:0] elig;

    always_comb begin
        elig = req & en & {NUM_M{~i_bit}};
        any  = |elig;
        idx  = '0;
        for (int k = NUM_M - 1; k >= 0; k--) begin
            if (elig[k]) idx = SEL_W'(k);
        end
        if (elig[prom]) idx = prom;
    end

    // R4: the reported winner is always an eligible source
    always_comb begin
        p_pick_eligible_r4: assert (!any || elig[idx])
            else $error("maskable winner not eligible");
    end
endmodule

// File: rtl/irq_ccr_bits.sv
module irq_ccr_bits #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             set_x,
    input  logic             rti,
    input  logic             rti_x,
    input  logic             rti_i,
    input  logic             ccr_we,
    input  logic             ccr_x,
    input  logic             ccr_i,
    input  logic             prom_we,
    input  logic [SEL_W-1:0] prom_wdata,
    output logic             x_bit,
    output logic             i_bit,
    output logic [SEL_W-1:0] prom
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_bit <= 1'b1;
            i_bit <= 1'b1;
            prom  <= '0;
        end else begin
            if (take) begin
                i_bit <= 1'b1;
                if (set_x) x_bit <= 1'b1;
            end else if (rti) begin
                i_bit <= rti_i;
                x_bit <= x_bit & rti_x;
            end else if (ccr_we) begin
                i_bit <= ccr_i;
                x_bit <= x_bit & ccr_x;
            end
            if (prom_we && i_bit) prom <= prom_wdata;
        end
    end

    // R6: promotion register frozen while I is clear
    p_prom_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prom_we && !i_bit) |=> $stable(prom));

    // R7: X only rises through an interrupt entry that sets it
    p_x_rise_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_bit) |-> $past(set_x && take));

    // R8: every entry leaves I set
    p_entry_sets_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> i_bit);
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_pkg::*;
#(
    parameter int NUM_M = 16,
    parameter int VEC_W = 16,
    parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE,
    localparam int SEL_W = $clog2(NUM_M),
    localparam int ID_W  = $clog2(NUM_FIXED + NUM_M)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic             clkmon_fail,
    input  logic             cop_fail,
    input  logic             illop_req,
    input  logic             swi_fetch,
    input  logic             vec_done,
    input  logic             xirq_req,
    input  logic [NUM_M-1:0] mreq,
    input  logic [NUM_M-1:0] men,
    input  logic             ack,
    input  logic             rti,
    input  logic             rti_x,
    input  logic             rti_i,
    input  logic             ccr_we,
    input  logic             ccr_x,
    input  logic             ccr_i,
    input  logic             prom_we,
    input  logic [SEL_W-1:0] prom_wdata,
    output logic             req_valid,
    output logic [ID_W-1:0]  req_id,
    output logic [VEC_W-1:0] req_vector,
    output logic             grant,
    output logic [ID_W-1:0]  grant_id,
    output logic             x_bit,
    output logic             i_bit
);
    lock_state_t state_q, state_d;
    logic             m_any;
    logic [SEL_W-1:0] m_idx;
    logic [SEL_W-1:0] prom;
    logic             win_any;
    logic [ID_W-1:0]  win_id;
    logic             take, set_x;

    irq_mask_pick #(.NUM_M(NUM_M), .SEL_W(SEL_W)) u_pick (
        .req(mreq), .en(men), .i_bit(i_bit), .prom(prom),
        .any(m_any), .idx(m_idx)
    );

    irq_ccr_bits #(.SEL_W(SEL_W)) u_ccr (
        .clk(clk), .rst_n(rst_n), .take(take), .set_x(set_x),
        .rti(rti), .rti_x(rti_x), .rti_i(rti_i),
        .ccr_we(ccr_we), .ccr_x(ccr_x), .ccr_i(ccr_i),
        .prom_we(prom_we), .prom_wdata(prom_wdata),
        .x_bit(x_bit), .i_bit(i_bit), .prom(prom)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions: T_SWI_ENTER, T_VEC_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (swi_fetch) state_d = ST_SWI_LOCK;
            ST_SWI_LOCK: if (vec_done)  state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // Fixed-order resolution
    always_comb begin
        win_any = 1'b1;
        win_id  = '0;
        if (rst_req)               win_id = ID_W'(ID_RESET);
        else if (clkmon_fail)      win_id = ID_W'(ID_CLKMON);
        else if (cop_fail)         win_id = ID_W'(ID_COP);
        else if (state_q == ST_SWI_LOCK) win_id = ID_W'(ID_SWI);
        else if (illop_req)        win_id = ID_W'(ID_ILLOP);
        else if (xirq_req && !x_bit) win_id = ID_W'(ID_XIRQ);
        else if (m_any)            win_id = ID_W'(NUM_FIXED) + ID_W'(m_idx);
        else                       win_any = 1'b0;
    end

    assign take  = ack && win_any;
    assign set_x = (win_id == ID_W'(ID_XIRQ)) || (win_id == ID_W'(ID_RESET));

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid  <= 1'b0;
            req_id     <= '0;
            req_vector <= VEC_TOP;
            grant      <= 1'b0;
            grant_id   <= '0;
        end else begin
            req_valid <= win_any;
            if (win_any) begin
                req_id     <= win_id;
                req_vector <= VEC_TOP - VEC_W'({win_id, 1'b0});
            end
            grant <= take;
            if (take) grant_id <= win_id;
        end
    end

    // R8: a grant only follows an acknowledge
    p_grant_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(ack));

    // R8: entry through the X-masked request sets both bits
    p_xirq_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_id == ID_W'(ID_XIRQ)) |-> (x_bit && i_bit));

    // R10: while locked nothing below SWI can win
    p_swi_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWI_LOCK) |-> (win_any && win_id <= ID_W'(ID_SWI)));

    // R3: with nothing eligible the reported code and vector hold
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> ($stable(req_id) && $stable(req_vector)));
endmodule

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req = 0, clkmon_fail = 0, cop_fail = 0, illop_req = 0;
    logic swi_fetch = 0, vec_done = 0, xirq_req = 0;
    logic [15:0] mreq = '0, men = '0;
    logic ack = 0, rti = 0, rti_x = 0, rti_i = 0;
    logic ccr_we = 0, ccr_x = 0, ccr_i = 0, prom_we = 0;
    logic [3:0] prom_wdata = '0;
    logic req_valid, grant, x_bit, i_bit;
    logic [4:0] req_id, grant_id;
    logic [15:0] req_vector;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_resolver u_irq_prio_resolver (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .clkmon_fail(clkmon_fail),
        .cop_fail(cop_fail), .illop_req(illop_req), .swi_fetch(swi_fetch),
        .vec_done(vec_done), .xirq_req(xirq_req), .mreq(mreq), .men(men),
        .ack(ack), .rti(rti), .rti_x(rti_x), .rti_i(rti_i), .ccr_we(ccr_we),
        .ccr_x(ccr_x), .ccr_i(ccr_i), .prom_we(prom_we), .prom_wdata(prom_wdata),
        .req_valid(req_valid), .req_id(req_id), .req_vector(req_vector),
        .grant(grant), .grant_id(grant_id), .x_bit(x_bit), .i_bit(i_bit)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int vec_of(input int id);
        return 16'hFFFE - 2 * id;
    endfunction

    // Expected winner from the requirements; -1 when nothing is eligible
    function automatic int model(input logic rs, cm, cp, il, xr, xb, ib,
                                 input logic [15:0] rq, en, input int p);
        logic [15:0] el;
        if (rs) return 0;
        if (cm) return 1;
        if (cp) return 2;
        if (il) return 3;
        if (xr && !xb) return 5;
        el = rq & en & {16{~ib}};
        if (el[p]) return 6 + p;
        for (int k = 0; k < 16; k++) if (el[k]) return 6 + k;
        return -1;
    endfunction

    task automatic chk_model(input string req, input int p);
        int e;
        e = model(rst_req, clkmon_fail, cop_fail, illop_req, xirq_req, x_bit, i_bit, mreq, men, p);
        chk(req, int'(req_valid), int'(e >= 0));
        if (e >= 0) begin
            chk(req, int'(req_id), e);
            chk("R2", int'(req_vector), vec_of(e));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R11 reset state
        chk("R11", int'(req_valid), 0);
        chk("R11", int'(req_id), 0);
        chk("R11", int'(req_vector), 16'hFFFE);
        chk("R11", int'(grant), 0);
        chk("R11", int'(x_bit), 1);
        chk("R11", int'(i_bit), 1);

        // R7: request blocked while X=1
        xirq_req = 1; cyc();
        chk("R7", int'(req_valid), 0);
        xirq_req = 0;

        // R6: write while I=1 accepted, write while I=0 ignored
        prom_we = 1; prom_wdata = 4'd5; cyc(); prom_we = 0;
        ccr_we = 1; ccr_i = 0; ccr_x = 0; cyc(); ccr_we = 0;
        chk("R7", int'(x_bit), 0);
        prom_we = 1; prom_wdata = 4'd9; cyc(); prom_we = 0;
        mreq = 16'h0224; men = 16'hFFFF; cyc();
        chk("R6", int'(req_id), 11);
        chk("R5", int'(req_vector), vec_of(11));

        // R7: software cannot set X
        ccr_we = 1; ccr_x = 1; ccr_i = 0; cyc(); ccr_we = 0;
        chk("R7", int'(x_bit), 0);

        // R3: hold when idle
        mreq = '0; cyc();
        chk("R3", int'(req_valid), 0);
        chk("R3", int'(req_id), 11);
        chk("R3", int'(req_vector), vec_of(11));

        // R4/R5/R2 sweep over promotion and patterns
        for (int p = 0; p < 16; p++) begin
            ccr_we = 1; ccr_i = 1; ccr_x = 0; cyc(); ccr_we = 0;
            prom_we = 1; prom_wdata = 4'(p); cyc(); prom_we = 0;
            ccr_we = 1; ccr_i = 0; cyc(); ccr_we = 0;
            for (int k = 0; k < 16; k++) begin
                mreq = (16'h1 << k) | (16'h1 << ((k + 5) % 16));
                men = 16'hFFFF; cyc();
                chk_model("R5", p);
                mreq = mreq | (16'h1 << p);
                men = ~(16'h1 << p); cyc();
                chk_model("R4", p);
            end
        end
        // R4: I=1 blocks maskable sources
        mreq = 16'hFFFF; men = 16'hFFFF;
        ccr_we = 1; ccr_i = 1; cyc(); ccr_we = 0; cyc();
        chk("R4", int'(req_valid), 0);
        ccr_we = 1; ccr_i = 0; cyc(); ccr_we = 0;

        // R1 fixed order sweep
        for (int v = 0; v < 32; v++) begin
            {xirq_req, illop_req, cop_fail, clkmon_fail, rst_req} = 5'(v);
            cyc();
            chk_model("R1", 15);
        end
        {xirq_req, illop_req, cop_fail, clkmon_fail, rst_req} = '0;

        // R8: maskable entry
        mreq = 16'h0008; cyc();
        ack = 1; cyc(); ack = 0;
        chk("R8", int'(grant), 1);
        chk("R8", int'(grant_id), 9);
        chk("R8", int'(i_bit), 1);
        chk("R8", int'(x_bit), 0);
        cyc();
        chk("R8", int'(grant), 0);

        // R8: X-masked entry
        ccr_we = 1; ccr_i = 0; ccr_x = 0; cyc(); ccr_we = 0;
        mreq = '0; xirq_req = 1; cyc();
        ack = 1; cyc(); ack = 0;
        chk("R8", int'(grant_id), 5);
        chk("R8", int'(x_bit), 1);
        chk("R8", int'(i_bit), 1);
        xirq_req = 0;

        // R9: restore
        rti = 1; rti_x = 0; rti_i = 0; cyc(); rti = 0;
        chk("R9", int'(x_bit), 0);
        chk("R9", int'(i_bit), 0);
        rti = 1; rti_x = 1; rti_i = 1; cyc(); rti = 0;
        chk("R9", int'(x_bit), 0);
        chk("R9", int'(i_bit), 1);

        // R10: SWI lock
        ccr_we = 1; ccr_i = 0; ccr_x = 0; cyc(); ccr_we = 0;
        illop_req = 1; xirq_req = 1; mreq = 16'h0001;
        swi_fetch = 1; cyc(); swi_fetch = 0; cyc();
        chk("R10", int'(req_id), 4);
        chk("R10", int'(req_vector), vec_of(4));
        cop_fail = 1; cyc();
        chk("R10", int'(req_id), 2);
        cop_fail = 0; vec_done = 1; cyc(); vec_done = 0;
        chk("R10", int'(req_id), 4);
        cyc();
        chk("R10", int'(req_id), 3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule